// File: doc/BRIEF.md
# Ethernet Receive Deframer with Pad Strip

This block sits after the line decoder of an Ethernet receiver. It takes the decoded serial stream, one bit per `rx_valid` strobe while `carrier` is high. It throws away the first eight bits of each carrier event and then hunts for the start-of-frame delimiter. Every bit after the delimiter is assembled into bytes, least significant bit first. Each byte is delivered on a byte stream with a start-of-frame flag on the first byte. When the carrier ends or a collision is reported, a separate end-of-frame strobe follows.

The two bytes after the source address are read as a length field. When auto-strip is enabled and that length is below the minimum data size, the bytes past the indicated data are still presented, but with `out_keep` low, so that storage further on drops them. The CRC is still run over every received byte. The end-of-frame strobe carries an FCS error flag and a drop flag. The drop flag tells the frame store to delete a runt or a frame that collided early. It is not raised when low-latency mode is on and the collision came after the low watermark.

Top module: `eth_rx_deframer`

## Requirements
- R1: After `carrier` rises, the first 8 bits strobed by `rx_valid` are ignored. The block then searches for the delimiter 0xD5, whose bits arrive in the order 1,0,1,0,1,0,1,1. A delimiter that falls inside the ignored bits does not start a frame.
- R2: After the delimiter, each group of 8 bits becomes one byte, with the first bit received as bit 0. Each byte is presented for one cycle on `out_data` with `out_valid` high. `out_sof` is high with the first byte only.
- R3: Bytes 12 and 13 after the delimiter (counting from 0) form the length field, byte 12 being the more significant. When `auto_strip` is high and the length is below 46, `out_keep` is high for bytes 0 to 13+length and low for all later bytes. Those later bytes are still presented with `out_valid`.
- R4: When `auto_strip` is low, or when the length field is 46 or more, `out_keep` is high for every delivered byte, whatever the real byte count.
- R5: The CRC-32 runs over every byte after the delimiter, including those with `out_keep` low. `out_fcs_err` is high with `out_eof` when the residue differs from 0xC704DD7B, written in conventional MSB-first form.
- R6: When `carrier` falls during a frame, `out_eof` pulses for one cycle after the last byte. `out_eof` and `out_valid` are never high in the same cycle, and bits left over after the last full byte are dropped.
- R7: A frame that ends with fewer than 64 bytes after the delimiter has `out_drop` high on its `out_eof`. A frame of 64 or more bytes that ends normally has `out_drop` low.
- R8: A `collision` during a frame ends it at once with `out_eof`. All further bits are ignored until `carrier` falls. `out_drop` is high if fewer than 64 bytes were received, unless `low_latency` is high and at least 12 bytes were received.
- R9: After reset, `out_valid`, `out_sof` and `out_eof` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier | input | 1 | Carrier present on the medium |
| rx_valid | input | 1 | Strobe: `rx_bit` holds a decoded bit |
| rx_bit | input | 1 | Decoded serial data bit |
| collision | input | 1 | Collision reported by the line interface |
| auto_strip | input | 1 | Enable suppression of pad and FCS on short frames |
| low_latency | input | 1 | Keep frames that collide after the low watermark |
| out_valid | output | 1 | Byte present on `out_data` |
| out_data | output | 8 | Received byte |
| out_sof | output | 1 | First byte of a frame |
| out_keep | output | 1 | Byte belongs to the delivered frame (low for stripped bytes) |
| out_eof | output | 1 | End-of-frame strobe |
| out_drop | output | 1 | With `out_eof`: frame is to be deleted |
| out_fcs_err | output | 1 | With `out_eof`: CRC residue mismatch |

## Verification
The assertions assume that `rx_valid` is low in the cycle `carrier` falls. They also assume that a collision is never raised in the same cycle as the last bit of a byte, so a byte strobe and an end strobe can never meet in the pipeline. The stimulus keeps to this. Each bit is held for two cycles with the strobe in the first one, and carrier and collision are changed only after a full byte and a few idle cycles. The CRC and frame contents are computed in the bench, and the frame lengths are chosen to sit on both sides of the 12- and 64-byte limits.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

    localparam logic [7:0]  SFD_BYTE  = 8'hD5;
    localparam logic [31:0] CRC_POLYR = 32'hEDB88320;

    typedef enum logic [2:0] {
        AL_IDLE,
        AL_DISCARD,
        AL_HUNT,
        AL_DATA,
        AL_SKIP
    } al_state_e;

    // Reflected CRC-32 over one byte, bit 0 first.
    function automatic logic [31:0] crc32_byte(input logic [31:0] crc, input logic [7:0] b);
        logic [31:0] c;
        c = crc;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ b[i]) c = {1'b0, c[31:1]} ^ CRC_POLYR;
            else             c = {1'b0, c[31:1]};
        end
        return c;
    endfunction

    function automatic logic [31:0] bitrev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

endpackage

// File: rtl/eth_rx_aligner.sv
module eth_rx_aligner
    import eth_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       carrier,
    input  logic       rx_valid,
    input  logic       rx_bit,
    input  logic       collision,
    output logic       byte_stb,
    output logic [7:0] byte_val,
    output logic       start_stb,
    output logic       end_stb,
    output logic       end_col
);

    typedef struct packed {
        al_state_e   state;
        logic [2:0]  cnt;
        logic [7:0]  sr;
        logic        byte_stb;
        logic        start_stb;
        logic        end_stb;
        logic        end_col;
    } al_regs_t;

    al_regs_t al_d, al_q;
    logic [7:0] sr_shift;

    always_comb begin
        al_d           = al_q;
        al_d.byte_stb  = 1'b0;
        al_d.start_stb = 1'b0;
        al_d.end_stb   = 1'b0;
        al_d.end_col   = 1'b0;
        sr_shift       = {rx_bit, al_q.sr[7:1]};
        case (al_q.state)
            AL_IDLE: begin
                if (carrier) begin
                    al_d.state = AL_DISCARD;
                    al_d.cnt   = '0;
                    al_d.sr    = '0;
                end
            end
            AL_DISCARD: begin
                if (!carrier)       al_d.state = AL_IDLE;
                else if (collision) al_d.state = AL_SKIP;
                else if (rx_valid) begin
                    al_d.sr  = sr_shift;
                    al_d.cnt = al_q.cnt + 3'd1;
                    if (al_q.cnt == 3'd7) al_d.state = AL_HUNT;
                end
            end
            AL_HUNT: begin
                if (!carrier)       al_d.state = AL_IDLE;
                else if (collision) al_d.state = AL_SKIP;
                else if (rx_valid) begin
                    al_d.sr = sr_shift;
                    if (sr_shift == SFD_BYTE) begin
                        al_d.state     = AL_DATA;
                        al_d.cnt       = '0;
                        al_d.start_stb = 1'b1;
                    end
                end
            end
            AL_DATA: begin
                if (collision) begin
                    al_d.state   = AL_SKIP;
                    al_d.end_stb = 1'b1;
                    al_d.end_col = 1'b1;
                end else if (!carrier) begin
                    al_d.state   = AL_IDLE;
                    al_d.end_stb = 1'b1;
                end else if (rx_valid) begin
                    al_d.sr  = sr_shift;
                    al_d.cnt = al_q.cnt + 3'd1;
                    if (al_q.cnt == 3'd7) al_d.byte_stb = 1'b1;
                end
            end
            default: begin
                if (!carrier) al_d.state = AL_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            al_q       <= '0;
            al_q.state <= AL_IDLE;
        end else begin
            al_q <= al_d;
        end
    end

    assign byte_stb  = al_q.byte_stb;
    assign byte_val  = al_q.sr;
    assign start_stb = al_q.start_stb;
    assign end_stb   = al_q.end_stb;
    assign end_col   = al_q.end_col;

    // R6: at most one frame event per cycle reaches the frame controller
    a_r6_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_stb, start_stb, end_stb}));

    // R8: once a collision ends a frame, no byte follows in the next cycle
    a_r8_quiet_after_col: assert property (@(posedge clk) disable iff (!rst_n)
        (end_stb && end_col) |=> !byte_stb);

endmodule

// File: rtl/eth_rx_crc.sv
module eth_rx_crc
    import eth_rx_pkg::*;
#(
    parameter logic [31:0] RESIDUE = 32'hC704DD7B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_stb,
    input  logic       byte_stb,
    input  logic [7:0] byte_val,
    output logic       crc_ok
);

    localparam logic [31:0] RESIDUE_R = bitrev32(RESIDUE);

    logic [31:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (start_stb)     crc_d = '1;
        else if (byte_stb) crc_d = crc32_byte(crc_q, byte_val);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end

    assign crc_ok = (crc_q == RESIDUE_R);

    // R5: every frame starts from an all-ones register
    a_r5_crc_seeded: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> (crc_q == 32'hFFFF_FFFF));

endmodule

// File: rtl/eth_rx_frame_ctl.sv
module eth_rx_frame_ctl #(
    parameter int CNT_W     = 11,
    parameter int MIN_FRAME = 64,
    parameter int LL_BYTES  = 12,
    parameter int MIN_DATA  = 46,
    parameter int LEN_POS   = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_stb,
    input  logic [7:0] byte_val,
    input  logic       start_stb,
    input  logic       end_stb,
    input  logic       end_col,
    input  logic       crc_ok,
    input  logic       auto_strip,
    input  logic       low_latency,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       out_keep,
    output logic       out_eof,
    output logic       out_drop,
    output logic       out_fcs_err
);

    localparam int              HDR_BYTES = LEN_POS + 2;
    localparam logic [CNT_W-1:0] IDX_MAX  = '1;
    localparam logic [CNT_W-1:0] MIN_C    = CNT_W'(MIN_FRAME);
    localparam logic [CNT_W-1:0] LL_C     = CNT_W'(LL_BYTES);
    localparam logic [CNT_W-1:0] HDR_C    = CNT_W'(HDR_BYTES);
    localparam logic [CNT_W-1:0] LPOS_C   = CNT_W'(LEN_POS);

    typedef struct packed {
        logic [CNT_W-1:0] idx;
        logic [7:0]       len_hi;
        logic [15:0]      len;
        logic             strip;
        logic             valid;
        logic [7:0]       data;
        logic             sof;
        logic             keep;
        logic             eof;
        logic             drop;
        logic             fcs_err;
    } fc_regs_t;

    fc_regs_t fc_d, fc_q;
    logic [16:0] keep_lim;
    logic [15:0] len_now;

    always_comb begin
        fc_d         = fc_q;
        fc_d.valid   = 1'b0;
        fc_d.sof     = 1'b0;
        fc_d.eof     = 1'b0;
        keep_lim     = 17'(HDR_BYTES) + {1'b0, fc_q.len};
        len_now      = {fc_q.len_hi, byte_val};
        if (start_stb) begin
            fc_d.idx   = '0;
            fc_d.strip = 1'b0;
        end else if (byte_stb) begin
            fc_d.valid = 1'b1;
            fc_d.data  = byte_val;
            fc_d.sof   = (fc_q.idx == '0);
            fc_d.keep  = (fc_q.idx < HDR_C) || !fc_q.strip || (17'(fc_q.idx) < keep_lim);
            if (fc_q.idx != IDX_MAX) fc_d.idx = fc_q.idx + 1'b1;
            if (fc_q.idx == LPOS_C) fc_d.len_hi = byte_val;
            if (fc_q.idx == LPOS_C + 1'b1) begin
                fc_d.len   = len_now;
                fc_d.strip = auto_strip && (len_now < 16'(MIN_DATA));
            end
        end else if (end_stb) begin
            fc_d.eof     = 1'b1;
            fc_d.fcs_err = !crc_ok;
            fc_d.drop    = (fc_q.idx < MIN_C) && !(end_col && low_latency && fc_q.idx >= LL_C);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fc_q <= '0;
        else        fc_q <= fc_d;
    end

    assign out_valid   = fc_q.valid;
    assign out_data    = fc_q.data;
    assign out_sof     = fc_q.sof;
    assign out_keep    = fc_q.keep;
    assign out_eof     = fc_q.eof;
    assign out_drop    = fc_q.drop;
    assign out_fcs_err = fc_q.fcs_err;

    // R6: end strobe never shares a cycle with a byte
    a_r6_eof_alone: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_eof && out_valid));

    // R2: start flag only accompanies a byte
    a_r2_sof_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    // R3: header bytes are always delivered
    a_r3_header_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && fc_q.idx < HDR_C) |=> out_keep);

    // R7: a full-size frame ending normally is kept
    a_r7_long_frame_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (end_stb && !end_col && fc_q.idx >= MIN_C) |=> !out_drop);

    // R8: low-latency collision past the watermark is kept
    a_r8_ll_collision_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (end_stb && end_col && low_latency && fc_q.idx >= LL_C) |=> !out_drop);

endmodule

// File: rtl/eth_rx_deframer.sv
module eth_rx_deframer #(
    parameter int          CNT_W     = 11,
    parameter int          MIN_FRAME = 64,
    parameter int          LL_BYTES  = 12,
    parameter int          MIN_DATA  = 46,
    parameter int          LEN_POS   = 12,
    parameter logic [31:0] RESIDUE   = 32'hC704DD7B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       carrier,
    input  logic       rx_valid,
    input  logic       rx_bit,
    input  logic       collision,
    input  logic       auto_strip,
    input  logic       low_latency,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       out_keep,
    output logic       out_eof,
    output logic       out_drop,
    output logic       out_fcs_err
);

    logic       byte_stb, start_stb, end_stb, end_col, crc_ok;
    logic [7:0] byte_val;

    eth_rx_aligner i_aligner (
        .clk       (clk),
        .rst_n     (rst_n),
        .carrier   (carrier),
        .rx_valid  (rx_valid),
        .rx_bit    (rx_bit),
        .collision (collision),
        .byte_stb  (byte_stb),
        .byte_val  (byte_val),
        .start_stb (start_stb),
        .end_stb   (end_stb),
        .end_col   (end_col)
    );

    eth_rx_crc #(.RESIDUE(RESIDUE)) i_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_stb (start_stb),
        .byte_stb  (byte_stb),
        .byte_val  (byte_val),
        .crc_ok    (crc_ok)
    );

    eth_rx_frame_ctl #(
        .CNT_W     (CNT_W),
        .MIN_FRAME (MIN_FRAME),
        .LL_BYTES  (LL_BYTES),
        .MIN_DATA  (MIN_DATA),
        .LEN_POS   (LEN_POS)
    ) i_frame_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_stb    (byte_stb),
        .byte_val    (byte_val),
        .start_stb   (start_stb),
        .end_stb     (end_stb),
        .end_col     (end_col),
        .crc_ok      (crc_ok),
        .auto_strip  (auto_strip),
        .low_latency (low_latency),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_sof     (out_sof),
        .out_keep    (out_keep),
        .out_eof     (out_eof),
        .out_drop    (out_drop),
        .out_fcs_err (out_fcs_err)
    );

endmodule

// File: tb/test_eth_rx_deframer.sv
module test_eth_rx_deframer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       carrier = 1'b0, rx_valid = 1'b0, rx_bit = 1'b0, collision = 1'b0;
    logic       auto_strip = 1'b1, low_latency = 1'b0;
    logic       out_valid, out_sof, out_keep, out_eof, out_drop, out_fcs_err;
    logic [7:0] out_data;

    int checks = 0;
    int fails  = 0;

    logic [7:0] frm [0:255];
    int         frm_n;
    logic [7:0] rx_data [0:255];
    logic       rx_keep [0:255];
    int         rx_n, sof_cnt, sof_idx, eof_cnt;
    logic       got_drop, got_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_rx_deframer i_eth_rx_deframer (
        .clk(clk), .rst_n(rst_n), .carrier(carrier), .rx_valid(rx_valid),
        .rx_bit(rx_bit), .collision(collision), .auto_strip(auto_strip),
        .low_latency(low_latency), .out_valid(out_valid), .out_data(out_data),
        .out_sof(out_sof), .out_keep(out_keep), .out_eof(out_eof),
        .out_drop(out_drop), .out_fcs_err(out_fcs_err)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rx_n < 256) begin
                rx_data[rx_n] = out_data;
                rx_keep[rx_n] = out_keep;
            end
            if (out_sof) begin
                sof_cnt = sof_cnt + 1;
                sof_idx = rx_n;
            end
            rx_n = rx_n + 1;
        end
        if (rst_n && out_eof) begin
            eof_cnt  = eof_cnt + 1;
            got_drop = out_drop;
            got_err  = out_fcs_err;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] bench_crc(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ frm[i][b];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        return c;
    endfunction

    task automatic build(input int len_field, input int payload, input bit bad_fcs);
        logic [31:0] f;
        for (int i = 0; i < 6; i++) frm[i] = 8'h10 + 8'(i);
        for (int i = 0; i < 6; i++) frm[6+i] = 8'h20 + 8'(i);
        frm[12] = 8'(len_field >> 8);
        frm[13] = 8'(len_field);
        for (int i = 0; i < payload; i++) frm[14+i] = 8'(i*7 + 3);
        f = ~bench_crc(14 + payload);
        for (int i = 0; i < 4; i++) frm[14+payload+i] = f[8*i +: 8];
        if (bad_fcs) frm[14+payload] = frm[14+payload] ^ 8'h01;
        frm_n = 14 + payload + 4;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit   = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int b = 0; b < 8; b++) send_bit(v[b]);
    endtask

    // odd_pre: the delimiter is placed inside the ignored leading bits
    task automatic send_frame(input int col_after, input bit odd_pre);
        rx_n = 0; sof_cnt = 0; sof_idx = -1; eof_cnt = 0; got_drop = 1'b0; got_err = 1'b0;
        @(negedge clk);
        carrier = 1'b1;
        repeat (3) @(negedge clk);
        if (odd_pre) begin
            send_byte(8'hD5);
            repeat (3) send_byte(8'h55);
        end else begin
            repeat (7) send_byte(8'h55);
        end
        send_byte(8'hD5);
        for (int i = 0; i < frm_n; i++) begin
            if (i == col_after) begin
                repeat (2) @(negedge clk);
                collision = 1'b1;
                @(negedge clk);
                collision = 1'b0;
            end
            send_byte(frm[i]);
        end
        repeat (3) @(negedge clk);
        carrier = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic check_frame(input string req, input int exp_n, input int keep_n,
                               input bit exp_drop, input int exp_err);
        int bad_d = -1, bad_k = -1;
        chk(eof_cnt == 1, req, "eof count", eof_cnt, 1);
        chk(sof_cnt == 1 && sof_idx == 0, req, "sof position", sof_idx, 0);
        chk(rx_n == exp_n, req, "bytes delivered", rx_n, exp_n);
        for (int i = 0; i < exp_n && i < rx_n; i++) begin
            if (bad_d < 0 && rx_data[i] !== frm[i]) bad_d = i;
            if (bad_k < 0 && rx_keep[i] !== (i < keep_n)) bad_k = i;
        end
        chk(bad_d < 0, req, "first wrong data byte index", bad_d, -1);
        chk(bad_k < 0, req, "first wrong keep index", bad_k, -1);
        chk(got_drop == exp_drop, req, "drop", int'(got_drop), int'(exp_drop));
        if (exp_err >= 0) chk(int'(got_err) == exp_err, req, "fcs error", int'(got_err), exp_err);
    endtask

    task automatic t_reset;
        chk(out_valid === 1'b0 && out_sof === 1'b0 && out_eof === 1'b0, "R9", "outputs after reset",
            int'({out_valid, out_sof, out_eof}), 0);
    endtask

    task automatic t_long_good;  // R2 R4 R5 R6 R7: full frame, length >= 46, kept whole
        auto_strip = 1'b1; low_latency = 1'b0;
        build(100, 100, 1'b0);
        send_frame(-1, 1'b0);
        check_frame("R2_R4_R7", 118, 118, 1'b0, 0);
    endtask

    task automatic t_short_strip;  // R3 R5: length 10, pad and FCS marked, CRC still good
        auto_strip = 1'b1; low_latency = 1'b0;
        build(10, 46, 1'b0);
        send_frame(-1, 1'b0);
        check_frame("R3_R5", 64, 24, 1'b0, 0);
    endtask

    task automatic t_short_nostrip;  // R4: strip disabled, everything kept
        auto_strip = 1'b0;
        build(10, 46, 1'b0);
        send_frame(-1, 1'b0);
        check_frame("R4", 64, 64, 1'b0, 0);
        auto_strip = 1'b1;
    endtask

    task automatic t_bad_fcs;  // R5
        build(100, 60, 1'b1);
        send_frame(-1, 1'b0);
        check_frame("R5", 78, 78, 1'b0, 1);
    endtask

    task automatic t_runt;  // R7: 40 bytes after delimiter, good CRC, still dropped
        build(60, 22, 1'b0);
        send_frame(-1, 1'b0);
        check_frame("R7", 40, 40, 1'b1, 0);
    endtask

    task automatic t_collision;  // R8
        low_latency = 1'b0;
        build(100, 100, 1'b0);
        send_frame(30, 1'b0);
        check_frame("R8_no_ll", 30, 30, 1'b1, -1);
        low_latency = 1'b1;
        send_frame(30, 1'b0);
        check_frame("R8_ll_late", 30, 30, 1'b0, -1);
        send_frame(8, 1'b0);
        check_frame("R8_ll_early", 8, 8, 1'b1, -1);
        send_frame(12, 1'b0);
        check_frame("R8_ll_edge", 12, 12, 1'b0, -1);
        low_latency = 1'b0;
    endtask

    task automatic t_discard;  // R1: delimiter in the ignored bits does not start a frame
        build(100, 100, 1'b0);
        send_frame(-1, 1'b1);
        check_frame("R1", 118, 118, 1'b0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_long_good();
        t_short_strip();
        t_short_nostrip();
        t_bad_fcs();
        t_runt();
        t_collision();
        t_discard();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule